// File: doc/BRIEF.md
# Automatic UART Flow Controller

This block sits beside a UART datapath and makes its pacing decisions. It watches the receive FIFO fill count against a high and a low threshold. Once the count reaches the high mark it can drive RTS inactive, or send a stop character to the far end, or both. Once the count has drained to the low mark it releases RTS or sends the resume character. In the other direction it holds back the local transmitter when CTS goes inactive. It does the same when a stop character arrives from the far end, and it lets transmission resume when the matching resume character arrives.

The FIFOs, serializer, deserializer and register file are outside this block. The block only sees the receive count and received characters with a strobe. It also sees a transmitter-idle level that marks a character boundary, meaning the last stop bit has left. It answers with two one-cycle start permissions: one for the next data byte and one for an in-band control character. A transmitter that is halfway through a frame always finishes it. The block also keeps two sticky status flags for the host interrupt logic.

Top module: `uart_flow_ctl`

## Requirements
- R1: After reset, rts_n is 0, both sticky flags are 0, no control character is pending, and tx_data_go equals tx_idle & tx_avail.
- R2: With auto_rts_en=1, rts_n goes to 1 on the clock edge after rx_level >= lvl_high. It returns to 0 on the clock edge after rx_level <= lvl_low. For any level between the two thresholds it keeps its previous value.
- R3: With auto_rts_en=0, rts_n stays 0 whatever the receive level.
- R4: With auto_cts_en=1, cts_n is sampled only on edges where tx_idle=1. A change of cts_n made while the transmitter is busy has no effect until tx_idle returns. While the sampled cts_n is 1, neither tx_data_go nor tx_ctl_go is asserted.
- R5: flow_evt is set on a 0-to-1 transition of cts_n when both auto_cts_en and cts_irq_en are 1. It is also set when the automatic RTS output goes inactive while rts_irq_en=1. It is cleared by flag_clr, and a set event wins over a clear. When the enable for an event is 0, that event leaves the flag at 0.
- R6: With sw_send_en=1, a rising of the internal full state queues xoff_char, and a falling of that state queues xon_char. The queued character is shown on tx_ctl_char. Each queued character is issued once through tx_ctl_go and is not repeated.
- R7: A queued control character blocks tx_data_go. tx_ctl_go and tx_data_go are never asserted together, and neither is asserted while tx_idle=0.
- R8: With sw_obey_en=1, a received character equal to xoff_char or xon_char gives rx_keep=0 in the strobe cycle. An xoff_char sets xoff_seen and blocks tx_data_go from the next boundary. An xon_char clears xoff_seen and the block.
- R9: With spec_det_en=1, a received character equal to spec_char sets xoff_seen but keeps rx_keep=1 and does not block transmission.
- R10: With sw_obey_en=0, received xon_char and xoff_char values are ordinary data: rx_keep=1, xoff_seen is unchanged and transmission is not blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| auto_rts_en | input | 1 | Enable automatic RTS from the receive level |
| auto_cts_en | input | 1 | Enable transmit gating by CTS |
| sw_send_en | input | 1 | Enable sending stop/resume characters |
| sw_obey_en | input | 1 | Enable acting on received stop/resume characters |
| spec_det_en | input | 1 | Enable special-character detection |
| rts_irq_en | input | 1 | Allow the RTS-inactive event to set flow_evt |
| cts_irq_en | input | 1 | Allow the CTS-inactive event to set flow_evt |
| lvl_high | input | LW | High threshold on the receive count |
| lvl_low | input | LW | Low threshold on the receive count |
| rx_level | input | LW | Current receive FIFO count |
| xon_char | input | DW | Resume character value |
| xoff_char | input | DW | Stop character value |
| spec_char | input | DW | Special character value |
| rx_stb | input | 1 | A received character is valid this cycle |
| rx_char | input | DW | Received character |
| rx_keep | output | 1 | Write the current received character into the FIFO |
| cts_n | input | 1 | Clear-to-send, active low |
| rts_n | output | 1 | Request-to-send, active low |
| tx_idle | input | 1 | Transmitter is at a character boundary |
| tx_avail | input | 1 | Transmit FIFO holds data |
| tx_data_go | output | 1 | Start the next data byte |
| tx_ctl_go | output | 1 | Start the control character on tx_ctl_char |
| tx_ctl_char | output | DW | Control character to send |
| flag_clr | input | 1 | Clear both sticky flags |
| flow_evt | output | 1 | Sticky flag: RTS or CTS went inactive |
| xoff_seen | output | 1 | Sticky flag: stop or special character received |

## Verification
The bench walks the receive level through the band between the thresholds. A design without hysteresis would toggle RTS there instead of holding its last state. A CTS change made while the transmitter is busy is checked for having no effect until the boundary. A design that gates at once would cut a frame short. A queued control character is checked for reaching the line ahead of waiting data, for going out once only, and for waiting while the transmitter is busy. Received stop/resume characters are checked for being consumed, while special characters must be kept. A design that swapped those two would lose data or fill the FIFO with control characters.

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl #(
  parameter int DW = 8,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          auto_rts_en,
  input  logic          auto_cts_en,
  input  logic          sw_send_en,
  input  logic          sw_obey_en,
  input  logic          spec_det_en,
  input  logic          rts_irq_en,
  input  logic          cts_irq_en,
  input  logic [LW-1:0] lvl_high,
  input  logic [LW-1:0] lvl_low,
  input  logic [LW-1:0] rx_level,
  input  logic [DW-1:0] xon_char,
  input  logic [DW-1:0] xoff_char,
  input  logic [DW-1:0] spec_char,
  input  logic          rx_stb,
  input  logic [DW-1:0] rx_char,
  output logic          rx_keep,
  input  logic          cts_n,
  output logic          rts_n,
  input  logic          tx_idle,
  input  logic          tx_avail,
  output logic          tx_data_go,
  output logic          tx_ctl_go,
  output logic [DW-1:0] tx_ctl_char,
  input  logic          flag_clr,
  output logic          flow_evt,
  output logic          xoff_seen
);

  logic full_q, sent_q, cts_q, rem_q, cts_blk, rem_blk;

  wire at_high  = rx_level >= lvl_high;
  wire at_low   = rx_level <= lvl_low;
  wire is_xon   = sw_obey_en && (rx_char == xon_char);
  wire is_xoff  = sw_obey_en && (rx_char == xoff_char);
  wire got_xon  = rx_stb && is_xon;
  wire got_xoff = rx_stb && is_xoff;
  wire got_spec = rx_stb && spec_det_en && (rx_char == spec_char);
  wire rts_set  = auto_rts_en && !full_q && at_high;
  wire cts_rise = cts_n && !cts_q;
  wire rem_d    = got_xoff ? 1'b1 : (got_xon ? 1'b0 : (rem_q && sw_obey_en));
  wire ctl_pend = sw_send_en && (full_q != sent_q);

  assign rx_keep     = !(is_xon || is_xoff);
  assign rts_n       = auto_rts_en && full_q;
  assign tx_ctl_char = full_q ? xoff_char : xon_char;
  assign tx_ctl_go   = tx_idle && ctl_pend && !cts_blk;
  assign tx_data_go  = tx_idle && tx_avail && !ctl_pend && !cts_blk && !rem_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      sent_q    <= 1'b0;
      cts_q     <= 1'b0;
      rem_q     <= 1'b0;
      cts_blk   <= 1'b0;
      rem_blk   <= 1'b0;
      flow_evt  <= 1'b0;
      xoff_seen <= 1'b0;
    end else begin
      if (at_high)     full_q <= 1'b1;
      else if (at_low) full_q <= 1'b0;

      if (!sw_send_en)    sent_q <= 1'b0;
      else if (tx_ctl_go) sent_q <= full_q;

      cts_q <= cts_n;
      rem_q <= rem_d;
      if (tx_idle) begin
        cts_blk <= auto_cts_en && cts_n;
        rem_blk <= rem_d;
      end

      if ((cts_irq_en && auto_cts_en && cts_rise) || (rts_irq_en && rts_set)) flow_evt <= 1'b1;
      else if (flag_clr)                                                    flow_evt <= 1'b0;

      if (got_xoff || got_spec)    xoff_seen <= 1'b1;
      else if (got_xon || flag_clr) xoff_seen <= 1'b0;
    end
  end

  p_one_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_data_go && tx_ctl_go));
  p_start_at_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_data_go || tx_ctl_go) |-> tx_idle);
  p_rts_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rts_n) && auto_rts_en && $past(auto_rts_en)) |-> $past(rx_level >= lvl_high));
  p_rts_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rts_n) && auto_rts_en) |-> $past(rx_level <= lvl_low));
  p_ctl_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ctl_go |-> sw_send_en);
  p_xoff_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && sw_obey_en && rx_char == xoff_char) |=> xoff_seen);
  p_cts_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_idle) && $past(auto_cts_en && cts_n)) |-> !(tx_data_go || tx_ctl_go));

endmodule

// File: tb/sim_uart_flow_ctl.sv
module sim_uart_flow_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic auto_rts_en = 0, auto_cts_en = 0, sw_send_en = 0, sw_obey_en = 0, spec_det_en = 0;
  logic rts_irq_en = 0, cts_irq_en = 0;
  logic [7:0] lvl_high = 8'd100, lvl_low = 8'd20, rx_level = 0;
  logic [7:0] xon_char = 8'h11, xoff_char = 8'h13, spec_char = 8'h7E;
  logic rx_stb = 0, cts_n = 0, tx_idle = 1, tx_avail = 1, flag_clr = 0;
  logic [7:0] rx_char = 0;
  logic rx_keep, rts_n, tx_data_go, tx_ctl_go, flow_evt, xoff_seen;
  logic [7:0] tx_ctl_char;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  uart_flow_ctl u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  localparam int NV = 11;
  localparam logic [15:0] HYS [NV] = '{
    {8'd0, 8'd0}, {8'd50, 8'd0}, {8'd99, 8'd0}, {8'd100, 8'd1}, {8'd60, 8'd1}, {8'd21, 8'd1},
    {8'd20, 8'd0}, {8'd80, 8'd0}, {8'd120, 8'd1}, {8'd128, 8'd1}, {8'd5, 8'd0}};

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rts_n", rts_n, 0);
    check("R1 flow_evt", flow_evt, 0);
    check("R1 xoff_seen", xoff_seen, 0);
    check("R1 ctl_go", tx_ctl_go, 0);
    check("R1 data_go", tx_data_go, 1);

    auto_rts_en = 1;
    for (int i = 0; i < NV; i++) begin
      rx_level = HYS[i][15:8];
      @(negedge clk);
      check("R2 rts_n hysteresis", rts_n, HYS[i][0]);
    end

    auto_rts_en = 0; rx_level = 128;
    @(negedge clk); @(negedge clk);
    check("R3 rts_n off", rts_n, 0);
    rx_level = 0;
    @(negedge clk);

    auto_cts_en = 1; tx_idle = 0; cts_n = 1;
    @(negedge clk); @(negedge clk);
    tx_idle = 1; #1;
    check("R4 busy change not taken", tx_data_go, 1);
    @(negedge clk);
    check("R4 cts blocks data", tx_data_go, 0);
    cts_n = 0;
    @(negedge clk);
    check("R4 cts release", tx_data_go, 1);

    cts_irq_en = 1; cts_n = 1;
    @(negedge clk);
    check("R5 cts event", flow_evt, 1);
    cts_n = 0; flag_clr = 1;
    @(negedge clk);
    flag_clr = 0;
    check("R5 clear", flow_evt, 0);
    cts_irq_en = 0; cts_n = 1;
    @(negedge clk);
    check("R5 cts event masked", flow_evt, 0);
    cts_n = 0;
    @(negedge clk); @(negedge clk);
    auto_rts_en = 1; rts_irq_en = 1; rx_level = 110;
    @(negedge clk);
    check("R5 rts event", flow_evt, 1);
    rx_level = 0; flag_clr = 1;
    @(negedge clk);
    flag_clr = 0; auto_rts_en = 0; rts_irq_en = 0; auto_cts_en = 0;
    @(negedge clk);

    sw_send_en = 1; rx_level = 110;
    @(negedge clk);
    check("R6 xoff queued", tx_ctl_go, 1);
    check("R6 xoff char", tx_ctl_char, 8'h13);
    check("R7 data held behind ctl", tx_data_go, 0);
    @(negedge clk);
    check("R6 no repeat", tx_ctl_go, 0);
    check("R7 data after ctl", tx_data_go, 1);
    rx_level = 10; tx_idle = 0;
    @(negedge clk);
    check("R7 ctl waits boundary", tx_ctl_go, 0);
    tx_idle = 1; #1;
    check("R6 xon queued", tx_ctl_go, 1);
    check("R6 xon char", tx_ctl_char, 8'h11);
    @(negedge clk);
    check("R6 xon once", tx_ctl_go, 0);
    sw_send_en = 0;

    sw_obey_en = 1; rx_stb = 1; rx_char = 8'h13; #1;
    check("R8 xoff consumed", rx_keep, 0);
    @(negedge clk);
    rx_stb = 0;
    check("R8 xoff flag", xoff_seen, 1);
    check("R8 tx suspended", tx_data_go, 0);
    rx_char = 8'h41; #1;
    check("R8 data kept", rx_keep, 1);
    rx_stb = 1; rx_char = 8'h11; #1;
    check("R8 xon consumed", rx_keep, 0);
    @(negedge clk);
    rx_stb = 0;
    check("R8 xon resumes", tx_data_go, 1);
    check("R8 xon clears flag", xoff_seen, 0);

    sw_obey_en = 0; rx_stb = 1; rx_char = 8'h13; #1;
    check("R10 xoff kept as data", rx_keep, 1);
    @(negedge clk);
    rx_stb = 0;
    check("R10 no flag", xoff_seen, 0);
    check("R10 no suspend", tx_data_go, 1);

    spec_det_en = 1; rx_stb = 1; rx_char = 8'h7E; #1;
    check("R9 special kept", rx_keep, 1);
    @(negedge clk);
    rx_stb = 0;
    check("R9 special flag", xoff_seen, 1);
    check("R9 no suspend", tx_data_go, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule